// File: doc/BRIEF.md
# Duplex Synthesizer Power and VCO Calibration Sequencer

This block governs the receive and transmit frequency synthesizers of a radio front end. It decides which synthesizer is powered from the duplex setting and the transmit/receive direction line. It issues one-cycle VCO calibration start pulses when the direction line toggles during the alert state, when the chip leaves the wait state for the alert state, and when software rewrites a synthesizer's integer frequency word. A single disable bit suppresses every one of these requests.

Each synthesizer has a lock detector that runs on the reference clock. It remembers whether a calibration has completed since the last start pulse. It then counts consecutive reference cycles with the analog lock indication high and raises a lock flag once a programmable number of cycles has elapsed. The detector can be off, can check once per power-up, or can check continuously. The analog PLL, the VCO and the calibration engine are outside the block; they report back through the done and lock inputs.

Top module: `dupsyn_ctrl`

## Requirements
- R1: When `duplex_fdd` is 0 (time-division), `rx_pwr_en` equals the inverse of `txnrx` and `tx_pwr_en` equals `txnrx`, both as sampled on the previous clock edge.
- R2: When `duplex_fdd` is 1 (frequency-division), both `rx_pwr_en` and `tx_pwr_en` are 1 on the cycle after it is sampled.
- R3: In time-division mode with `top_state` = 1 (alert), a 0-to-1 change of `txnrx` between two sampled edges produces a one-cycle `tx_cal_start` pulse after the second edge, and a 1-to-0 change produces a one-cycle `rx_cal_start` pulse.
- R4: When `top_state` moves from 0 (wait) to 1 (alert) between two sampled edges, both start pulses fire for one cycle. Codes 2 and 3 are other operating states that trigger nothing.
- R5: A one-cycle pulse on `rx_intword_wr` or `tx_intword_wr` produces the matching start pulse on the next cycle, whatever the state and duplex mode.
- R6: While `cal_dis` is 1, no start pulse is issued for any trigger, and stored calibration-done history is left untouched.
- R7: `lock_cnt_sel` codes 0, 1, 2 and 3 select a lock window of 256, 512, 1024 and 2048 reference cycles.
- R8: A synthesizer's lock flag rises on the edge at which its PLL lock input has been sampled high for the selected window of consecutive edges. This counting happens only while the synthesizer is powered and a calibration done has been seen since its last start pulse.
- R9: With `lock_mode` = 2 (continuous), the lock flag falls on the first edge at which the PLL lock input is sampled low.
- R10: With `lock_mode` = 1 (once), a lock flag that has risen stays high through later loss of PLL lock, until the synthesizer powers down or a new start pulse is issued.
- R11: With `lock_mode` = 0 (off) or 3 (reserved), the lock flags stay 0.
- R12: Powering a synthesizer down clears its lock flag on the following edge but keeps its calibration-done history, so after power-up it relocks without a new done.
- R13: The calibration-done history is set by the done input and cleared by that synthesizer's own start pulse; a start pulse takes priority when both occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duplex_fdd | input | 1 | 1 = frequency-division, 0 = time-division |
| txnrx | input | 1 | Direction line, 1 = transmit |
| top_state | input | 2 | 0 wait, 1 alert, 2/3 other states |
| rx_intword_wr | input | 1 | Pulse: receive integer frequency word written |
| tx_intword_wr | input | 1 | Pulse: transmit integer frequency word written |
| cal_dis | input | 1 | Masks all calibration triggers |
| lock_mode | input | 2 | 0 off, 1 once, 2 continuous, 3 reserved |
| lock_cnt_sel | input | 2 | Lock window select |
| rx_cal_done | input | 1 | Receive VCO calibration finished |
| tx_cal_done | input | 1 | Transmit VCO calibration finished |
| rx_pll_lock | input | 1 | Receive PLL analog lock indication |
| tx_pll_lock | input | 1 | Transmit PLL analog lock indication |
| rx_pwr_en | output | 1 | Receive synthesizer power enable |
| tx_pwr_en | output | 1 | Transmit synthesizer power enable |
| rx_cal_start | output | 1 | Receive VCO calibration start pulse |
| tx_cal_start | output | 1 | Transmit VCO calibration start pulse |
| rx_locked | output | 1 | Receive lock flag |
| tx_locked | output | 1 | Transmit lock flag |

## Verification
A stale direction sample or state sample shows up as a missing or doubled start pulse on the very next cycle, and a wrong power enable shows up one cycle after the direction line changes. A corrupted lock counter or done history shows up as a lock flag rising early or late. That error is visible only at the end of the selected window, up to 2048 cycles later, so the bench holds lock steady across full windows of every size. A flag that fails to clear appears on the cycle after lock loss or power-down. All six outputs are compared against a behavioural model on every clock.

// File: rtl/dupsyn_pkg.sv
package dupsyn_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_ALERT = 2'd1,
    ST_OPA   = 2'd2,
    ST_OPB   = 2'd3
  } top_st_e;

  typedef enum logic [1:0] {
    LD_OFF  = 2'd0,
    LD_ONCE = 2'd1,
    LD_CONT = 2'd2,
    LD_RSVD = 2'd3
  } lk_mode_e;

  localparam int NSYN   = 2;
  localparam int IDX_RX = 0;
  localparam int IDX_TX = 1;
endpackage

// File: rtl/dupsyn_trig.sv
module dupsyn_trig
  import dupsyn_pkg::*;
#(
  parameter int N = NSYN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fdd,
  input  logic         txnrx,
  input  logic [1:0]   top_state,
  input  logic [N-1:0] intword_wr,
  input  logic         cal_dis,
  output logic [N-1:0] pwr_en,
  output logic [N-1:0] cal_start
);
  logic         txnrx_q;
  top_st_e      state_q;
  top_st_e      state_in;
  logic         dir_rise, dir_fall, in_alert, enter_alert;
  logic [N-1:0] req;
  logic [N-1:0] pwr_n, start_n;
  logic         hist_we;

  assign state_in = top_st_e'(top_state);

  always_comb begin
    dir_rise    = txnrx & ~txnrx_q;
    dir_fall    = ~txnrx & txnrx_q;
    in_alert    = (state_in == ST_ALERT);
    enter_alert = (state_q == ST_WAIT) && in_alert;
    req            = intword_wr;
    req[IDX_RX]    = req[IDX_RX] | enter_alert | (~fdd & in_alert & dir_fall);
    req[IDX_TX]    = req[IDX_TX] | enter_alert | (~fdd & in_alert & dir_rise);
    start_n        = cal_dis ? '0 : req;
    pwr_n[IDX_RX]  = fdd | ~txnrx;
    pwr_n[IDX_TX]  = fdd | txnrx;
    hist_we        = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txnrx_q <= 1'b0;
      state_q <= ST_WAIT;
    end else if (hist_we) begin
      txnrx_q <= txnrx;
      state_q <= state_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_en    <= '0;
      cal_start <= '0;
    end else begin
      pwr_en    <= pwr_n;
      cal_start <= start_n;
    end
  end
endmodule

// File: rtl/dupsyn_lockdet.sv
module dupsyn_lockdet
  import dupsyn_pkg::*;
#(
  parameter int LOCK_BASE = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_en,
  input  logic       cal_start,
  input  logic       cal_done,
  input  logic       lock_in,
  input  logic [1:0] mode,
  input  logic [1:0] cnt_sel,
  output logic       locked
);
  localparam int MAXWIN = LOCK_BASE * 8;
  localparam int CNT_W  = $clog2(MAXWIN + 1);

  lk_mode_e         mode_e;
  logic [CNT_W-1:0] cnt, cnt_n, target, cnt_inc;
  logic             lk_n, cal_ok, cal_ok_n, active, cnt_we;

  assign mode_e = lk_mode_e'(mode);

  always_comb begin
    target   = CNT_W'(LOCK_BASE) << cnt_sel;
    cnt_inc  = cnt + 1'b1;
    active   = pwr_en & cal_ok & ((mode_e == LD_ONCE) | (mode_e == LD_CONT));
    cal_ok_n = cal_start ? 1'b0 : (cal_done ? 1'b1 : cal_ok);
    cnt_n    = cnt;
    lk_n     = locked;
    if (!active) begin
      cnt_n = '0;
      lk_n  = 1'b0;
    end else if ((mode_e == LD_ONCE) && locked) begin
      cnt_n = cnt;
      lk_n  = 1'b1;
    end else if (!lock_in) begin
      cnt_n = '0;
      lk_n  = 1'b0;
    end else begin
      cnt_n = (cnt >= target) ? cnt : cnt_inc;
      lk_n  = (cnt_n >= target);
    end
    cnt_we = (cnt_n != cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_we) cnt <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      cal_ok <= 1'b0;
    end else begin
      locked <= lk_n;
      cal_ok <= cal_ok_n;
    end
  end
endmodule

// File: rtl/dupsyn_ctrl.sv
module dupsyn_ctrl
  import dupsyn_pkg::*;
#(
  parameter int LOCK_BASE = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       duplex_fdd,
  input  logic       txnrx,
  input  logic [1:0] top_state,
  input  logic       rx_intword_wr,
  input  logic       tx_intword_wr,
  input  logic       cal_dis,
  input  logic [1:0] lock_mode,
  input  logic [1:0] lock_cnt_sel,
  input  logic       rx_cal_done,
  input  logic       tx_cal_done,
  input  logic       rx_pll_lock,
  input  logic       tx_pll_lock,
  output logic       rx_pwr_en,
  output logic       tx_pwr_en,
  output logic       rx_cal_start,
  output logic       tx_cal_start,
  output logic       rx_locked,
  output logic       tx_locked
);
  logic [NSYN-1:0] wr_v, done_v, lock_v, pwr_v, start_v, locked_v;

  assign wr_v   = {tx_intword_wr, rx_intword_wr};
  assign done_v = {tx_cal_done, rx_cal_done};
  assign lock_v = {tx_pll_lock, rx_pll_lock};

  dupsyn_trig #(.N(NSYN)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .fdd        (duplex_fdd),
    .txnrx      (txnrx),
    .top_state  (top_state),
    .intword_wr (wr_v),
    .cal_dis    (cal_dis),
    .pwr_en     (pwr_v),
    .cal_start  (start_v)
  );

  for (genvar g = 0; g < NSYN; g++) begin : g_lk
    dupsyn_lockdet #(.LOCK_BASE(LOCK_BASE)) u_lk (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_en    (pwr_v[g]),
      .cal_start (start_v[g]),
      .cal_done  (done_v[g]),
      .lock_in   (lock_v[g]),
      .mode      (lock_mode),
      .cnt_sel   (lock_cnt_sel),
      .locked    (locked_v[g])
    );
  end

  assign rx_pwr_en    = pwr_v[IDX_RX];
  assign tx_pwr_en    = pwr_v[IDX_TX];
  assign rx_cal_start = start_v[IDX_RX];
  assign tx_cal_start = start_v[IDX_TX];
  assign rx_locked    = locked_v[IDX_RX];
  assign tx_locked    = locked_v[IDX_TX];
endmodule

// File: rtl/dupsyn_ctrl_chk.sv
module dupsyn_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       duplex_fdd,
  input logic       txnrx,
  input logic [1:0] top_state,
  input logic       cal_dis,
  input logic [1:0] lock_mode,
  input logic       rx_pll_lock,
  input logic       tx_pll_lock,
  input logic       rx_pwr_en,
  input logic       tx_pwr_en,
  input logic       rx_cal_start,
  input logic       tx_cal_start,
  input logic       rx_locked,
  input logic       tx_locked
);
  logic [1:0] pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 2'd0;
    else if (pv != 2'd2) pv <= pv + 2'd1;
  end

  p_tdd_power_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 2'd0 && !$past(duplex_fdd)) |->
      (rx_pwr_en == !$past(txnrx) && tx_pwr_en == $past(txnrx)));

  p_fdd_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 2'd0 && $past(duplex_fdd)) |-> (rx_pwr_en && tx_pwr_en));

  p_tx_edge_cal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pv == 2'd2 && $past(top_state) == 2'd1 && !$past(duplex_fdd) && !$past(cal_dis)
      && $past(txnrx) && !$past(txnrx, 2)) |-> tx_cal_start);

  p_enter_alert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pv == 2'd2 && $past(top_state, 2) == 2'd0 && $past(top_state) == 2'd1
      && !$past(cal_dis)) |-> (rx_cal_start && tx_cal_start));

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 2'd0 && $past(cal_dis)) |-> (!rx_cal_start && !tx_cal_start));

  p_cont_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 2'd0 && $past(lock_mode) == 2'd2 && !$past(rx_pll_lock)) |-> !rx_locked);

  p_off_modes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 2'd0 && ($past(lock_mode) == 2'd0 || $past(lock_mode) == 2'd3))
      |-> (!rx_locked && !tx_locked));

  p_rise_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 2'd0 && $rose(tx_locked)) |-> ($past(tx_pll_lock) && $past(tx_pwr_en)));
endmodule

bind dupsyn_ctrl dupsyn_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .duplex_fdd   (duplex_fdd),
  .txnrx        (txnrx),
  .top_state    (top_state),
  .cal_dis      (cal_dis),
  .lock_mode    (lock_mode),
  .rx_pll_lock  (rx_pll_lock),
  .tx_pll_lock  (tx_pll_lock),
  .rx_pwr_en    (rx_pwr_en),
  .tx_pwr_en    (tx_pwr_en),
  .rx_cal_start (rx_cal_start),
  .tx_cal_start (tx_cal_start),
  .rx_locked    (rx_locked),
  .tx_locked    (tx_locked)
);

// File: tb/tb_dupsyn_ctrl.sv
`timescale 1ns/1ps
module tb_dupsyn_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic duplex_fdd, txnrx, rx_wr, tx_wr, cal_dis;
  logic [1:0] top_state, lock_mode, lock_cnt_sel;
  logic rx_done, tx_done, rx_lock, tx_lock;
  logic rx_pwr, tx_pwr, rx_st, tx_st, rx_lk, tx_lk;

  always #5 clk = ~clk;

  dupsyn_ctrl dut (
    .clk(clk), .rst_n(rst_n), .duplex_fdd(duplex_fdd), .txnrx(txnrx),
    .top_state(top_state), .rx_intword_wr(rx_wr), .tx_intword_wr(tx_wr),
    .cal_dis(cal_dis), .lock_mode(lock_mode), .lock_cnt_sel(lock_cnt_sel),
    .rx_cal_done(rx_done), .tx_cal_done(tx_done),
    .rx_pll_lock(rx_lock), .tx_pll_lock(tx_lock),
    .rx_pwr_en(rx_pwr), .tx_pwr_en(tx_pwr),
    .rx_cal_start(rx_st), .tx_cal_start(tx_st),
    .rx_locked(rx_lk), .tx_locked(tx_lk)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference model
  bit m_txq;
  int m_stq;
  bit m_pwr[2], m_st[2], m_ok[2], m_lk[2];
  int m_cnt[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_txq = 0; m_stq = 0;
      for (int i = 0; i < 2; i++) begin
        m_pwr[i] = 0; m_st[i] = 0; m_ok[i] = 0; m_lk[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      bit req[2], done[2], lk_in[2], wr[2], act;
      bit n_pwr[2], n_st[2], n_ok[2], n_lk[2];
      int n_cnt[2];
      int tgt;
      done[0] = rx_done; done[1] = tx_done;
      lk_in[0] = rx_lock; lk_in[1] = tx_lock;
      wr[0] = rx_wr; wr[1] = tx_wr;
      req[0] = wr[0] || (m_stq == 0 && top_state == 1) ||
               (!duplex_fdd && top_state == 1 && !txnrx && m_txq);
      req[1] = wr[1] || (m_stq == 0 && top_state == 1) ||
               (!duplex_fdd && top_state == 1 && txnrx && !m_txq);
      n_pwr[0] = duplex_fdd || !txnrx;
      n_pwr[1] = duplex_fdd || txnrx;
      tgt = 256 << lock_cnt_sel;
      for (int i = 0; i < 2; i++) begin
        n_st[i] = req[i] && !cal_dis;
        n_ok[i] = m_st[i] ? 1'b0 : (done[i] ? 1'b1 : m_ok[i]);
        act = m_pwr[i] && m_ok[i] && (lock_mode == 1 || lock_mode == 2);
        n_cnt[i] = m_cnt[i]; n_lk[i] = m_lk[i];
        if (!act) begin n_cnt[i] = 0; n_lk[i] = 0; end
        else if (lock_mode == 1 && m_lk[i]) n_lk[i] = 1;
        else if (!lk_in[i]) begin n_cnt[i] = 0; n_lk[i] = 0; end
        else begin
          n_cnt[i] = (m_cnt[i] >= tgt) ? m_cnt[i] : m_cnt[i] + 1;
          n_lk[i] = (n_cnt[i] >= tgt);
        end
      end
      m_txq = txnrx; m_stq = top_state;
      m_pwr = n_pwr; m_st = n_st; m_ok = n_ok; m_lk = n_lk; m_cnt = n_cnt;
    end
  end

  task automatic cmp(input string req, input string nm, input bit act, input bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, nm, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("R1/R2", "rx_pwr_en", rx_pwr, m_pwr[0]);
      cmp("R1/R2", "tx_pwr_en", tx_pwr, m_pwr[1]);
      cmp("R3 R4 R5 R6", "rx_cal_start", rx_st, m_st[0]);
      cmp("R3 R4 R5 R6", "tx_cal_start", tx_st, m_st[1]);
      cmp("R7 R8 R9 R10 R11 R12 R13", "rx_locked", rx_lk, m_lk[0]);
      cmp("R7 R8 R9 R10 R11 R12 R13", "tx_locked", tx_lk, m_lk[1]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_done();
    rx_done = 1; tx_done = 1; step(1); rx_done = 0; tx_done = 0;
  endtask

  initial begin
    rst_n = 0; duplex_fdd = 0; txnrx = 0; top_state = 0; rx_wr = 0; tx_wr = 0;
    cal_dis = 0; lock_mode = 0; lock_cnt_sel = 0; rx_done = 0; tx_done = 0;
    rx_lock = 0; tx_lock = 0;
    step(4);                                   // reset state
    rst_n = 1; step(3);                        // R1: rx powered in time-division
    top_state = 1; step(3);                    // R4: wait to alert starts both
    pulse_done(); step(2);                     // R13: history set
    lock_mode = 2; rx_lock = 1; tx_lock = 1; step(262);   // R7 R8 rx locks at 256
    rx_lock = 0; step(2); rx_lock = 1; step(260);         // R9 drop and relock
    txnrx = 1; step(3);                        // R3 tx start, R12 rx flag cleared
    tx_done = 1; step(1); tx_done = 0; step(262);          // R8 tx lock
    txnrx = 0; step(3);                        // R3 rx start
    cal_dis = 1; step(1);                      // R6: every trigger masked
    txnrx = 1; step(2); txnrx = 0; step(2);
    rx_wr = 1; tx_wr = 1; step(1); rx_wr = 0; tx_wr = 0;
    top_state = 0; step(2); top_state = 1; step(3);
    cal_dis = 0; top_state = 2; step(2);
    duplex_fdd = 1; lock_mode = 1; lock_cnt_sel = 1; step(2);   // R2
    pulse_done(); step(520);                   // R7 512 window, R10 once mode
    rx_lock = 0; tx_lock = 0; step(20);        // R10 flags hold
    rx_lock = 1; tx_lock = 1;
    duplex_fdd = 0; txnrx = 0; step(5);        // R12 tx powered down, flag cleared
    duplex_fdd = 1; step(520);                 // R12 relock without new done
    rx_wr = 1; step(1); rx_wr = 0; step(2);    // R5 rx word write
    tx_wr = 1; step(1); tx_wr = 0; step(2);    // R5 tx word write
    rx_wr = 1; tx_done = 1; step(1); rx_wr = 0; tx_done = 0; step(2);
    rx_done = 1; step(1); rx_done = 0;
    lock_mode = 3; step(300);                  // R11 reserved mode
    lock_mode = 0; step(300);                  // R11 off mode
    lock_mode = 2; lock_cnt_sel = 3; step(2060);   // R7 2048 window
    lock_cnt_sel = 2; step(5);
    tx_lock = 0; step(3); tx_lock = 1; step(1030);   // R7 1024 window, R9
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule